// File: doc/BRIEF.md
# Performance Event Counter Bank

This block holds ten 48-bit event counters for one processor core. Counter 0 counts core clock cycles and counter 1 counts retired instructions. Counters 2 to 9 each pick one line from a 256-wide vector of event strobes, using an 8-bit event code. Each counter runs only when two conditions hold: its count-enable bit is set, and the privilege filter for the current level (user or kernel) allows it. When an increment moves a counter's bit 47 from 0 to 1, the counter's overflow status bit is set. The fast-interrupt output combines the overflow status, the per-counter interrupt enables and a global interrupt-mode field.

Software reaches every register through a single-cycle register port. A write takes effect at the next clock edge. The read data is combinational and shows the register state before any write in the same cycle. The address map is: counters 0 to 9 at addresses 0 to 9, control register 0 at 10, the privilege filter register at 11, event-select registers at 12 and 13, and the overflow status register at 14. Address 15 reads as zero.

Top module: `pmc_bank`

## Requirements
- R1: After reset, every register reads zero and `fastIrq` is low.
- R2: When counter 0 is enabled and its privilege filter allows it, counter 0 increments on every clock. Counter 1 increments on each cycle with `instRetire` high. The event-select registers have no effect on either counter.
- R3: Counter i (2..5) counts `evtStrobe[code]`, with code taken from address 12 bits [(i-2)*8+7:(i-2)*8]. Counter i (6..9) takes its code from address 13 bits [(i-6)*8+7:(i-6)*8]. Only bits [31:0] of these two registers are stored.
- R4: In control register 0 (address 10), the count enables for counters 0..7 are at bits [7:0] and the count enables for counters 8..9 are at bits [33:32]. A disabled counter holds its value.
- R5: In the filter register (address 11), the user-level enables are at bits [9:0] and the kernel-level enables are at bits [25:16]. A counter increments only when the bit for the current level is set (`privUser` high selects user, low selects kernel).
- R6: An increment that takes bit 47 from 0 to 1 sets status bit i at address 14. Counters wrap at 48 bits. A software write that sets bit 47 does not set the status bit.
- R7: Writing 1 to a status bit clears it; writing 0 leaves it unchanged. An overflow in the same cycle as a clear leaves the bit set.
- R8: A software write to a counter replaces that cycle's increment.
- R9: `fastIrq` is high when both hold: the interrupt mode, bits [10:8] of address 10, is not 0 (4 is the normal fast-interrupt setting), and some status bit is set whose interrupt enable is set. The interrupt enables are at bits [19:12] for counters 0..7 and bits [45:44] for counters 8..9.
- R10: The interrupt-active flag, bit 11 of address 10, is set on the clock after any cycle with `fastIrq` high. Software loads the flag by writing bit 11. A write of 0 has no effect while `fastIrq` stays high.
- R11: Unmapped bits and address 15 read as zero. The read data is combinational on `regAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| privUser | input | 1 | Current privilege level: 1 user, 0 kernel |
| instRetire | input | 1 | Strobe for one retired instruction |
| evtStrobe | input | 256 | Event strobe vector, indexed by event code |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regWdata | input | 64 | Write data |
| regRdata | output | 64 | Read data for `regAddr` |
| fastIrq | output | 1 | Fast-interrupt request |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a software write to a counter and that counter's own increment. The second pair is a write-1-to-clear of a status bit and a fresh overflow of the same counter. The bench provokes both with directed sequences: it loads counter 0 two counts below the bit-47 boundary, then issues the status clear on exactly the edge where the crossing happens. It also writes counters while they count freely under random events. A behavioural reference model runs alongside the design and judges every cycle; after a collision the model expects the written value and a status bit that stays set.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  parameter int NumCnt    = 10;
  parameter int FixedCnt  = 2;
  parameter int CntW      = 48;
  parameter int CodeW     = 8;
  parameter int NumEvt    = 1 << CodeW;
  parameter int RegW      = 64;
  parameter int AddrW     = 4;
  parameter int SelPerReg = 4;
  parameter int ModeW     = 3;

  localparam int LoCnt = 8;
  localparam int HiCnt = NumCnt - LoCnt;

  // control register 0 field positions
  localparam int CenLoLsb = 0;
  localparam int ModeLsb  = 8;
  localparam int IactBit  = 11;
  localparam int IenLoLsb = 12;
  localparam int CenHiLsb = 32;
  localparam int IenHiLsb = 44;
  // privilege filter register
  localparam int UserLsb  = 0;
  localparam int KernLsb  = 16;

  localparam logic [ModeW-1:0] ModeOff  = '0;
  localparam logic [ModeW-1:0] ModeFast = ModeW'(4);

  localparam logic [AddrW-1:0] AddrCtrl0 = AddrW'(NumCnt);
  localparam logic [AddrW-1:0] AddrPriv  = AddrW'(NumCnt + 1);
  localparam logic [AddrW-1:0] AddrSelLo = AddrW'(NumCnt + 2);
  localparam logic [AddrW-1:0] AddrSelHi = AddrW'(NumCnt + 3);
  localparam logic [AddrW-1:0] AddrStat  = AddrW'(NumCnt + 4);

  typedef logic [SelPerReg-1:0][CodeW-1:0] selReg_t;

  typedef struct packed {
    logic [NumCnt-1:0]             gate;
    logic [NumCnt-1:0]             load;
    logic [CntW-1:0]               loadVal;
    logic [NumCnt-1:0][CodeW-1:0]  code;
  } dpStrobe_t;
endpackage

// File: rtl/pmc_lane.sv
module pmc_lane
  import pmc_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            load,
  input  logic [CntW-1:0] loadVal,
  input  logic            gate,
  input  logic            evHit,
  output logic [CntW-1:0] cnt,
  output logic            ovfHit
);
  logic [CntW-1:0] cntNxt;
  logic            bump;

  assign cntNxt = cnt + CntW'(1);
  assign bump   = gate && evHit && !load;
  assign ovfHit = bump && !cnt[CntW-1] && cntNxt[CntW-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cnt <= '0;
    else if (load)  cnt <= loadVal;
    else if (bump)  cnt <= cntNxt;
  end
endmodule

// File: rtl/pmc_datapath.sv
module pmc_datapath
  import pmc_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  dpStrobe_t                   strobe,
  input  logic [NumEvt-1:0]           evtStrobe,
  input  logic                        instRetire,
  output logic [NumCnt-1:0][CntW-1:0] cntVal,
  output logic [NumCnt-1:0]           ovfHit
);
  logic [NumCnt-1:0] evHit;

  for (genvar g = 0; g < NumCnt; g++) begin : gLane
    if (g == 0) begin : gCycle
      assign evHit[g] = 1'b1;
    end else if (g == 1) begin : gInst
      assign evHit[g] = instRetire;
    end else begin : gSel
      assign evHit[g] = evtStrobe[strobe.code[g]];
    end

    pmc_lane i_lane (
      .clk     (clk),
      .rstN    (rstN),
      .load    (strobe.load[g]),
      .loadVal (strobe.loadVal),
      .gate    (strobe.gate[g]),
      .evHit   (evHit[g]),
      .cnt     (cntVal[g]),
      .ovfHit  (ovfHit[g])
    );
  end
endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        privUser,
  input  logic                        regWr,
  input  logic [AddrW-1:0]            regAddr,
  input  logic [RegW-1:0]             regWdata,
  input  logic [NumCnt-1:0][CntW-1:0] cntVal,
  input  logic [NumCnt-1:0]           ovfHit,
  output dpStrobe_t                   strobe,
  output logic [RegW-1:0]             regRdata,
  output logic                        fastIrq,
  output logic [NumCnt-1:0]           ovfStatus,
  output logic [ModeW-1:0]            intMode,
  output logic                        iactFlag
);
  logic [NumCnt-1:0] cntEnQ, irqEnQ, userEnQ, kernEnQ, ovfQ;
  logic [ModeW-1:0]  modeQ;
  logic              iactQ;
  selReg_t           selLoQ, selHiQ;

  logic wrCtrl0, wrPriv, wrSelLo, wrSelHi, wrStat, irqCond;
  logic [RegW-1:0] ctrl0Img, privImg;

  assign wrCtrl0 = regWr && (regAddr == AddrCtrl0);
  assign wrPriv  = regWr && (regAddr == AddrPriv);
  assign wrSelLo = regWr && (regAddr == AddrSelLo);
  assign wrSelHi = regWr && (regAddr == AddrSelHi);
  assign wrStat  = regWr && (regAddr == AddrStat);

  assign irqCond = (modeQ != ModeOff) && |(ovfQ & irqEnQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntEnQ  <= '0;
      irqEnQ  <= '0;
      modeQ   <= ModeOff;
      iactQ   <= 1'b0;
      userEnQ <= '0;
      kernEnQ <= '0;
      selLoQ  <= '0;
      selHiQ  <= '0;
      ovfQ    <= '0;
    end else begin
      if (wrCtrl0) begin
        cntEnQ <= {regWdata[CenHiLsb +: HiCnt], regWdata[CenLoLsb +: LoCnt]};
        irqEnQ <= {regWdata[IenHiLsb +: HiCnt], regWdata[IenLoLsb +: LoCnt]};
        modeQ  <= regWdata[ModeLsb +: ModeW];
      end
      iactQ <= (wrCtrl0 ? regWdata[IactBit] : iactQ) | irqCond;
      if (wrPriv) begin
        userEnQ <= regWdata[UserLsb +: NumCnt];
        kernEnQ <= regWdata[KernLsb +: NumCnt];
      end
      if (wrSelLo) selLoQ <= regWdata[SelPerReg*CodeW-1:0];
      if (wrSelHi) selHiQ <= regWdata[SelPerReg*CodeW-1:0];
      ovfQ <= (wrStat ? (ovfQ & ~regWdata[NumCnt-1:0]) : ovfQ) | ovfHit;
    end
  end

  // strobes to the datapath
  always_comb begin
    strobe.loadVal = regWdata[CntW-1:0];
    for (int i = 0; i < NumCnt; i++) begin
      strobe.gate[i] = cntEnQ[i] && (privUser ? userEnQ[i] : kernEnQ[i]);
      strobe.load[i] = regWr && (regAddr == AddrW'(i));
      if (i < FixedCnt)
        strobe.code[i] = '0;
      else if (i < FixedCnt + SelPerReg)
        strobe.code[i] = selLoQ[(i - FixedCnt) % SelPerReg];
      else
        strobe.code[i] = selHiQ[(i - FixedCnt) % SelPerReg];
    end
  end

  // register images
  always_comb begin
    ctrl0Img = '0;
    ctrl0Img[CenLoLsb +: LoCnt] = cntEnQ[LoCnt-1:0];
    ctrl0Img[CenHiLsb +: HiCnt] = cntEnQ[NumCnt-1:LoCnt];
    ctrl0Img[IenLoLsb +: LoCnt] = irqEnQ[LoCnt-1:0];
    ctrl0Img[IenHiLsb +: HiCnt] = irqEnQ[NumCnt-1:LoCnt];
    ctrl0Img[ModeLsb +: ModeW]  = modeQ;
    ctrl0Img[IactBit]           = iactQ;
    privImg = '0;
    privImg[UserLsb +: NumCnt]  = userEnQ;
    privImg[KernLsb +: NumCnt]  = kernEnQ;
  end

  always_comb begin
    regRdata = '0;
    for (int i = 0; i < NumCnt; i++)
      if (regAddr == AddrW'(i)) regRdata[CntW-1:0] = cntVal[i];
    case (regAddr)
      AddrCtrl0: regRdata = ctrl0Img;
      AddrPriv:  regRdata = privImg;
      AddrSelLo: regRdata[SelPerReg*CodeW-1:0] = selLoQ;
      AddrSelHi: regRdata[SelPerReg*CodeW-1:0] = selHiQ;
      AddrStat:  regRdata[NumCnt-1:0] = ovfQ;
      default:   ;
    endcase
  end

  assign fastIrq   = irqCond;
  assign ovfStatus = ovfQ;
  assign intMode   = modeQ;
  assign iactFlag  = iactQ;
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              privUser,
  input  logic              instRetire,
  input  logic [NumEvt-1:0] evtStrobe,
  input  logic              regWr,
  input  logic [AddrW-1:0]  regAddr,
  input  logic [RegW-1:0]   regWdata,
  output logic [RegW-1:0]   regRdata,
  output logic              fastIrq
);
  dpStrobe_t                   strobe;
  logic [NumCnt-1:0][CntW-1:0] cntVal;
  logic [NumCnt-1:0]           ovfHit;
  logic [NumCnt-1:0]           ovfStatus;
  logic [ModeW-1:0]            intMode;
  logic                        iactFlag;

  pmc_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .privUser  (privUser),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .cntVal    (cntVal),
    .ovfHit    (ovfHit),
    .strobe    (strobe),
    .regRdata  (regRdata),
    .fastIrq   (fastIrq),
    .ovfStatus (ovfStatus),
    .intMode   (intMode),
    .iactFlag  (iactFlag)
  );

  pmc_datapath i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .evtStrobe  (evtStrobe),
    .instRetire (instRetire),
    .cntVal     (cntVal),
    .ovfHit     (ovfHit)
  );
endmodule

// File: rtl/pmc_bank_check.sv
module pmc_bank_check
  import pmc_pkg::*;
(
  input logic                        clk,
  input logic                        rstN,
  input logic                        regWr,
  input logic [AddrW-1:0]            regAddr,
  input logic                        fastIrq,
  input dpStrobe_t                   strobe,
  input logic [NumCnt-1:0][CntW-1:0] cntVal,
  input logic [NumCnt-1:0]           ovfHit,
  input logic [NumCnt-1:0]           ovfStatus,
  input logic [ModeW-1:0]            intMode,
  input logic                        iactFlag
);
  assert_cycle_count_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.gate[0] && !strobe.load[0]) |=> cntVal[0] == $past(cntVal[0]) + CntW'(1));

  assert_irq_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    (intMode == ModeOff) |-> !fastIrq);

  assert_iact_set_R10: assert property (@(posedge clk) disable iff (!rstN)
    fastIrq |=> iactFlag);

  for (genvar g = 0; g < NumCnt; g++) begin : gLaneChk
    assert_hold_disabled_R4: assert property (@(posedge clk) disable iff (!rstN)
      (!strobe.gate[g] && !strobe.load[g]) |=> $stable(cntVal[g]));

    assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
      strobe.load[g] |=> cntVal[g] == $past(strobe.loadVal));

    assert_ovf_latched_R6: assert property (@(posedge clk) disable iff (!rstN)
      ovfHit[g] |=> ovfStatus[g]);

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
      (ovfStatus[g] && !(regWr && regAddr == AddrStat)) |=> ovfStatus[g]);
  end
endmodule

bind pmc_bank pmc_bank_check i_check (
  .clk       (clk),
  .rstN      (rstN),
  .regWr     (regWr),
  .regAddr   (regAddr),
  .fastIrq   (fastIrq),
  .strobe    (strobe),
  .cntVal    (cntVal),
  .ovfHit    (ovfHit),
  .ovfStatus (ovfStatus),
  .intMode   (intMode),
  .iactFlag  (iactFlag)
);

// File: tb/test_pmc_bank.sv
module test_pmc_bank;
  localparam int Period = 10;

  logic         clk = 1'b0;
  logic         rstN;
  logic         privUser, instRetire, regWr;
  logic [255:0] evtStrobe;
  logic [3:0]   regAddr;
  logic [63:0]  regWdata;
  logic [63:0]  regRdata;
  logic         fastIrq;

  int    errors = 0;
  int    checks = 0;
  bit    started = 0;
  bit    done = 0;
  bit    randEv = 0;
  string curTag = "R1";

  // reference model state
  logic [47:0] mCnt [10];
  logic [63:0] mC0, mC1;
  logic [31:0] mSel0, mSel1;
  logic [9:0]  mSt;
  logic        mIact;

  localparam logic [63:0] C0Mask = 64'h0000_3003_000F_F7FF;
  localparam logic [63:0] C1Mask = 64'h0000_0000_03FF_03FF;

  always #(Period/2) clk = ~clk;

  pmc_bank i_pmc_bank (
    .clk(clk), .rstN(rstN), .privUser(privUser), .instRetire(instRetire),
    .evtStrobe(evtStrobe), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .fastIrq(fastIrq)
  );

  function automatic bit mCen(int i);
    return (i < 8) ? mC0[i] : mC0[32 + i - 8];
  endfunction
  function automatic bit mIen(int i);
    return (i < 8) ? mC0[12 + i] : mC0[44 + i - 8];
  endfunction
  function automatic bit mIrq();
    bit any = 0;
    for (int i = 0; i < 10; i++) if (mSt[i] && mIen(i)) any = 1;
    return (mC0[10:8] != 3'd0) && any;
  endfunction
  function automatic logic [63:0] mRead(logic [3:0] a);
    if (a < 10) return {16'h0, mCnt[a]};
    case (a)
      4'd10: return mC0 | (64'(mIact) << 11);
      4'd11: return mC1;
      4'd12: return {32'h0, mSel0};
      4'd13: return {32'h0, mSel1};
      4'd14: return {54'h0, mSt};
      default: return 64'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (!rstN) begin
      for (int i = 0; i < 10; i++) mCnt[i] = '0;
      mC0 = '0; mC1 = '0; mSel0 = '0; mSel1 = '0; mSt = '0; mIact = 0;
    end else begin
      bit          irqNow;
      logic [9:0]  setBits;
      irqNow  = mIrq();
      setBits = '0;
      for (int i = 0; i < 10; i++) begin
        bit ev, ok;
        logic [7:0]  code;
        logic [47:0] n;
        if (i < 6) code = mSel0[((i - 2) & 3) * 8 +: 8];
        else       code = mSel1[((i - 6) & 3) * 8 +: 8];
        ev = (i == 0) ? 1'b1 : (i == 1) ? instRetire : evtStrobe[code];
        ok = mCen(i) && (privUser ? mC1[i] : mC1[16 + i]) && ev;
        if (regWr && regAddr == 4'(i)) mCnt[i] = regWdata[47:0];
        else if (ok) begin
          n = mCnt[i] + 48'd1;
          if (!mCnt[i][47] && n[47]) setBits[i] = 1;
          mCnt[i] = n;
        end
      end
      if (regWr && regAddr == 4'd14) mSt = mSt & ~regWdata[9:0];
      mSt   = mSt | setBits;
      mIact = ((regWr && regAddr == 4'd10) ? regWdata[11] : mIact) | irqNow;
      if (regWr && regAddr == 4'd10) mC0 = regWdata & C0Mask;
      if (regWr && regAddr == 4'd11) mC1 = regWdata & C1Mask;
      if (regWr && regAddr == 4'd12) mSel0 = regWdata[31:0];
      if (regWr && regAddr == 4'd13) mSel1 = regWdata[31:0];
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // compare every cycle, after inputs settle and before the next edge
  always @(negedge clk) begin
    #(Period/4);
    if (started && !done) begin
      chk({curTag, " rdata"}, regRdata, mRead(regAddr));
      chk("R9 fastIrq", {63'h0, fastIrq}, {63'h0, mIrq()});
    end
  end

  task automatic step(bit wr, logic [3:0] a, logic [63:0] d);
    @(negedge clk);
    regWr = wr; regAddr = a; regWdata = d;
    if (randEv) begin
      for (int k = 0; k < 8; k++) evtStrobe[k*32 +: 32] = $urandom;
      instRetire = $urandom_range(0, 1);
    end
  endtask

  task automatic idle(int n, logic [3:0] a);
    for (int k = 0; k < n; k++) step(0, a, 64'h0);
  endtask

  initial begin
    #(Period * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 0; privUser = 1; instRetire = 0; regWr = 0; regAddr = 0;
    regWdata = 0; evtStrobe = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state over all addresses
    curTag = "R1";
    for (int a = 0; a < 16; a++) step(0, 4'(a), 0);
    // R11 unmapped bits and address
    curTag = "R11";
    step(1, 4'd12, 64'hFFFF_FFFF_FFFF_FFFF);
    step(1, 4'd10, 64'hFFFF_F7FF_FFF0_0000);
    idle(2, 4'd15); idle(1, 4'd12); idle(1, 4'd10);
    step(1, 4'd10, 64'h0);
    // R2 fixed counters, selects with junk
    curTag = "R2";
    randEv = 1;
    step(1, 4'd11, 64'h0000_0000_03FF_03FF);
    step(1, 4'd13, 64'h1234_5678_9ABC_DEF0);
    step(1, 4'd10, 64'h0000_0000_0000_0003);
    idle(10, 4'd0); idle(10, 4'd1);
    // R3 event selects
    curTag = "R3";
    step(1, 4'd12, 64'h0000_0000_8040_2010);
    step(1, 4'd13, 64'h0000_0000_FF7F_0301);
    step(1, 4'd10, 64'h0000_0003_0000_00FF);
    for (int a = 2; a < 10; a++) idle(4, 4'(a));
    // R4 enable split
    curTag = "R4";
    step(1, 4'd10, 64'h0000_0002_0000_00A5);
    for (int a = 0; a < 10; a++) idle(2, 4'(a));
    step(1, 4'd10, 64'h0000_0001_0000_005A);
    for (int a = 0; a < 10; a++) idle(2, 4'(a));
    // R5 privilege filter
    curTag = "R5";
    step(1, 4'd10, 64'h0000_0003_0000_00FF);
    step(1, 4'd11, 64'h0000_0000_0155_02AA);
    for (int k = 0; k < 30; k++) begin
      privUser = $urandom_range(0, 1);
      step(0, 4'($urandom_range(0, 9)), 0);
    end
    privUser = 1;
    step(1, 4'd11, 64'h0000_0000_03FF_03FF);
    // R6 overflow, wrap, write of bit 47
    curTag = "R6";
    step(1, 4'd0, 64'h0000_7FFF_FFFF_FFFD);
    idle(4, 4'd14);
    step(1, 4'd0, 64'h0000_FFFF_FFFF_FFFE);
    idle(3, 4'd0);
    step(1, 4'd2, 64'h0000_8000_0000_0000);
    idle(3, 4'd14);
    // R7 clear colliding with a new overflow
    curTag = "R7";
    step(1, 4'd14, 64'h3FF);
    idle(1, 4'd14);
    step(1, 4'd0, 64'h0000_7FFF_FFFF_FFFE);
    idle(1, 4'd14);
    step(1, 4'd14, 64'h001);
    idle(2, 4'd14);
    step(1, 4'd14, 64'h000);
    idle(1, 4'd14);
    // R8 write while counting
    curTag = "R8";
    for (int k = 0; k < 10; k++) begin
      step(1, 4'(k), 64'(k * 1000 + 7));
      idle(1, 4'(k));
    end
    // R9 interrupt gating
    curTag = "R9";
    step(1, 4'd0, 64'h0000_7FFF_FFFF_FFFF);
    idle(2, 4'd14);
    step(1, 4'd10, 64'h0000_0003_0000_04FF);
    idle(3, 4'd10);
    step(1, 4'd10, 64'h0000_3003_000F_F0FF);
    idle(3, 4'd10);
    step(1, 4'd10, 64'h0000_3003_000F_F4FF);
    idle(2, 4'd10);
    // R10 active flag
    curTag = "R10";
    step(1, 4'd10, 64'h0000_3003_000F_F4FF);
    idle(2, 4'd10);
    step(1, 4'd14, 64'h3FF);
    step(1, 4'd10, 64'h0000_0003_0000_00FF);
    idle(3, 4'd10);
    step(1, 4'd10, 64'h0000_0003_0000_08FF);
    idle(2, 4'd10);
    // random mix across all functions
    curTag = "R8";
    for (int k = 0; k < 600; k++) begin
      logic [63:0] d;
      logic [3:0]  a;
      a = 4'($urandom_range(0, 15));
      d = {$urandom, $urandom};
      if (a < 10 && $urandom_range(0, 1)) d = 64'h0000_7FFF_FFFF_FFF0 + 64'($urandom_range(0, 15));
      privUser = $urandom_range(0, 1);
      step($urandom_range(0, 9) < 3, a, d);
    end
    idle(2, 4'd14);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule